// File: doc/BRIEF.md
# Serial Register Control Port

This block is a four-wire serial slave that gives a host controller write and read access to a small bank of configuration registers. The host lowers a latch line and clocks in a 24-bit frame, most significant bit first. The top byte holds a seven-bit device address and a direction flag. The middle byte selects a register, and the low byte carries the data. A write frame updates its register only when the latch returns high and the frame has the right length. A read frame turns on the data-out line for the final byte and shifts the selected register out on it.

The serial pins are sampled by the block's own core clock through synchronizers. The host clock and latch can therefore be fully unrelated to any other clock on the chip. The register contents leave the block as a flat configuration vector. One bit of register 1 is not stored. Reads return a lock flag from an input pin in its place, and writes cannot change it.

Top module: `spi_regport`

## Requirements
- R1: After reset, every configuration output bit is 0 and `sdo_en` is low.
- R2: A frame is 24 bits, MSB first, sampled on rising `sck` while `cs_n` is low. Bits 23:17 hold the device address 0x04, bit 16 is the direction (0 write, 1 read), bits 15:8 hold the register index and bits 7:0 hold the data. A write updates `cfg_out[8*i +: 8]` of register i when `cs_n` rises.
- R3: A frame whose bits 23:17 differ from 0x04 has no effect. It writes nothing, and `sdo_en` stays low during it.
- R4: A write frame that has fewer or more than 24 rising `sck` edges before `cs_n` rises is discarded.
- R5: In a read frame, `sdo_en` goes high after the falling `sck` edge that follows the 16th rising edge. The selected register then appears on `sdo`, MSB first, one bit per falling edge, valid before each of rising edges 17 to 24.
- R6: `sdo_en` returns low once `cs_n` is high, and it is low outside matched read frames.
- R7: Register indices 5 to 13 and all indices above 16 are reserved. Writes to them change nothing, and reads of them return 0.
- R8: Bit 3 of register 1 reads back as the `lock_in` input. Writes do not affect it, and `cfg_out` carries 0 in that position.
- R9: A read frame does not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame latch, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Output enable for `sdo`; low means high impedance |
| lock_in | input | 1 | Read-only lock flag shown in register 1 bit 3 |
| cfg_out | output | 136 | Register contents, register i in bits 8*i+7:8*i |

## Verification
The assertions assume that `cs_n`, `sck` and `sdi` each stay steady for several core clocks around every transition. This lets the synchronizers deliver clean, single edges. They also assume that `sdi` is stable before each rising `sck`. The stimulus keeps every serial half period at eight core clocks. It changes `sdi` only together with a falling `sck`, and it holds `cs_n` steady for eight or more clocks around the frame boundaries. Within those limits, random register indices, data values, device addresses and frame lengths are mixed with directed checks of the lock bit and the reserved indices.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CNT_W      = 5;
  localparam int BYTE_W     = 8;

  typedef struct packed {
    logic [6:0]        dev;
    logic              rd;
    logic [BYTE_W-1:0] idx;
    logic [BYTE_W-1:0] val;
  } frame_t;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] src;
      if (s == 0) begin : g_first
        assign src = d;
      end else begin : g_next
        assign src = stg[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= src;
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_regport_engine.sv
module spi_regport_engine
  import spi_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_idx,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_val,
  output logic              sdo,
  output logic              sdo_en,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] HDR_END = CNT_W'(2 * BYTE_W);
  localparam logic [CNT_W-1:0] FRM_END = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                  sck_q, cs_q;
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic [BYTE_W-1:0]     osh_q, osh_n;
  logic                  sdo_q, sdo_n, oe_q, oe_n;
  logic                  we_q, we_n;
  logic [BYTE_W-1:0]     wi_q, wi_n, wv_q, wv_n;
  logic                  rise, fall, cs_rise, rd_hit;
  frame_t                frm;

  assign frm     = frame_t'(sh_q);
  assign rise    = sck_s & ~sck_q & ~cs_s;
  assign fall    = ~sck_s & sck_q & ~cs_s;
  assign cs_rise = cs_s & ~cs_q;
  // at the header boundary the received 16 bits sit in the low half
  assign rd_hit  = (cnt_q == HDR_END) && (sh_q[15:9] == DEV_ID) && sh_q[8];
  assign rd_idx  = sh_q[7:0];

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    osh_n = osh_q;
    sdo_n = sdo_q;
    oe_n  = oe_q;
    we_n  = 1'b0;
    wi_n  = wi_q;
    wv_n  = wv_q;
    if (cs_s) begin
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (rise) begin
      sh_n  = {sh_q[FRAME_BITS-2:0], sdi_s};
      cnt_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end else if (fall) begin
      if (rd_hit) begin
        sdo_n = rd_data[BYTE_W-1];
        osh_n = {rd_data[BYTE_W-2:0], 1'b0};
        oe_n  = 1'b1;
      end else if (oe_q) begin
        sdo_n = osh_q[BYTE_W-1];
        osh_n = {osh_q[BYTE_W-2:0], 1'b0};
      end
    end
    if (cs_rise && (cnt_q == FRM_END) && (frm.dev == DEV_ID) && !frm.rd) begin
      we_n = 1'b1;
      wi_n = frm.idx;
      wv_n = frm.val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      sh_q  <= '0;
      cnt_q <= '0;
      osh_q <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
      we_q  <= 1'b0;
      wi_q  <= '0;
      wv_q  <= '0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      osh_q <= osh_n;
      sdo_q <= sdo_n;
      oe_q  <= oe_n;
      we_q  <= we_n;
      wi_q  <= wi_n;
      wv_q  <= wv_n;
    end
  end

  assign wr_en   = we_q;
  assign wr_idx  = wi_q;
  assign wr_val  = wv_q;
  assign sdo     = sdo_q;
  assign sdo_en  = oe_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/spi_regport_regfile.sv
module spi_regport_regfile #(
  parameter int NUM_REGS  = 17,
  parameter int DW        = 8,
  parameter int RSV_FIRST = 5,
  parameter int RSV_LAST  = 13,
  parameter int LOCK_REG  = 1,
  parameter int LOCK_BIT  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             wr_idx,
  input  logic [DW-1:0]          wr_val,
  input  logic [7:0]             rd_idx,
  input  logic                   lock_in,
  output logic [DW-1:0]          rd_data,
  output logic [NUM_REGS*DW-1:0] cfg_flat
);
  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i >= RSV_FIRST && i <= RSV_LAST) begin : g_rsv
        assign cfg_flat[i*DW +: DW] = '0;
      end else begin : g_live
        localparam logic [DW-1:0] KEEP =
          (i == LOCK_REG) ? ~(DW'(1) << LOCK_BIT) : '1;
        logic [DW-1:0] q, d;
        always_comb begin
          d = q;
          if (wr_en && (wr_idx == 8'(i))) d = wr_val & KEEP;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= d;
        end
        assign cfg_flat[i*DW +: DW] = q;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_idx == 8'(k)) rd_data = cfg_flat[k*DW +: DW];
    end
    if (rd_idx == 8'(LOCK_REG)) rd_data[LOCK_BIT] = lock_in;
  end
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int         NUM_REGS    = 17,
  parameter logic [6:0] DEV_ID      = 7'h04,
  parameter int         RSV_FIRST   = 5,
  parameter int         RSV_LAST    = 13,
  parameter int         LOCK_REG    = 1,
  parameter int         LOCK_BIT    = 3,
  parameter int         SYNC_STAGES = 2,
  localparam int        CFG_W       = NUM_REGS * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_en,
  input  logic             lock_in,
  output logic [CFG_W-1:0] cfg_out
);
  logic [2:0]        pins_s;
  logic              cs_s, sck_s, sdi_s;
  logic [BYTE_W-1:0] rd_data, rd_idx, wr_idx, wr_val;
  logic              wr_en;
  logic [CNT_W-1:0]  bit_cnt;

  spi_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, sdi}), .q(pins_s)
  );
  assign {cs_s, sck_s, sdi_s} = pins_s;

  spi_regport_engine #(.DEV_ID(DEV_ID)) u_eng (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_val(wr_val), .sdo(sdo), .sdo_en(sdo_en), .bit_cnt(bit_cnt)
  );

  spi_regport_regfile #(
    .NUM_REGS(NUM_REGS), .DW(BYTE_W), .RSV_FIRST(RSV_FIRST), .RSV_LAST(RSV_LAST),
    .LOCK_REG(LOCK_REG), .LOCK_BIT(LOCK_BIT)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_idx(rd_idx), .lock_in(lock_in), .rd_data(rd_data), .cfg_flat(cfg_out)
  );
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int NUM_REGS  = 17,
  parameter int RSV_FIRST = 5,
  parameter int RSV_LAST  = 13,
  parameter int LOCK_REG  = 1,
  parameter int LOCK_BIT  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_s,
  input logic                  sdo_en,
  input logic                  wr_en,
  input logic [7:0]            wr_idx,
  input logic [4:0]            bit_cnt,
  input logic [NUM_REGS*8-1:0] cfg_out
);
  // R6: a high latch clears the output enable on the next edge
  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_en);

  // R5: the enable only turns on at the header boundary
  p_oe_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> (bit_cnt == 5'd16));

  // R2/R9: configuration moves only after a write strobe
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_out));

  // R7: strobes aimed at reserved or absent indices change nothing
  p_rsv_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_idx >= 8'(RSV_FIRST) && wr_idx <= 8'(RSV_LAST)) ||
               wr_idx >= 8'(NUM_REGS))) |=> $stable(cfg_out));

  // R8: the lock position is never stored
  p_lock_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out[LOCK_REG*8 + LOCK_BIT] == 1'b0);

  // R4: a write strobe only follows the latch rising with a full count
  p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> cs_s);
endmodule

bind spi_regport spi_regport_chk #(
  .NUM_REGS(NUM_REGS), .RSV_FIRST(RSV_FIRST), .RSV_LAST(RSV_LAST),
  .LOCK_REG(LOCK_REG), .LOCK_BIT(LOCK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdo_en(sdo_en), .wr_en(wr_en),
  .wr_idx(wr_idx), .bit_cnt(bit_cnt), .cfg_out(cfg_out)
);

// File: tb/spi_regport_test.sv
module spi_regport_test;
  localparam int NREG = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, lock_in = 1'b0;
  logic sdo, sdo_en;
  logic [NREG*8-1:0] cfg_out;

  int checks = 0, errors = 0;
  logic [7:0] model [NREG];
  bit done = 1'b0;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .lock_in(lock_in), .cfg_out(cfg_out)
  );

  always #4 clk = ~clk;

  function automatic bit is_rsv(input int a);
    return (a >= 5 && a <= 13) || a >= NREG;
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    logic [7:0] v;
    if (is_rsv(a)) return 8'h00;
    v = model[a];
    if (a == 1) v[3] = lock_in;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_cfg(input string req);
    logic ok = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      if (cfg_out[i*8 +: 8] !== (is_rsv(i) ? 8'h00 : model[i])) begin
        ok = 1'b0;
        $display("FAIL %s reg %0d actual=%h expected=%h", req, i, cfg_out[i*8 +: 8], model[i]);
      end
    end
    checks++;
    if (!ok) errors++;
  endtask

  task automatic xfer(input logic [23:0] f, input int nb,
                      output logic [7:0] rb, output logic oe_any, output logic oe_data);
    rb = 8'h00; oe_any = 1'b0; oe_data = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sck = 1'b0;
      sdi = (i < 24) ? f[23-i] : 1'b0;
      repeat (8) @(negedge clk);
      if (sdo_en) oe_any = 1'b1;
      if (i >= 16 && i < 24) begin
        rb = {rb[6:0], sdo};
        if (!sdo_en) oe_data = 1'b0;
      end
      sck = 1'b1;
      repeat (8) @(negedge clk);
    end
    sck = 1'b0;
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] dev, input int a, input logic [7:0] v, input int nb);
    logic [7:0] rb; logic oa, od;
    xfer({dev, 1'b0, 8'(a), v}, nb, rb, oa, od);
    if (dev == 7'h04 && nb == 24 && !is_rsv(a)) model[a] = (a == 1) ? (v & 8'hF7) : v;
    check("R6 sdo_en low after write frame", {31'd0, sdo_en}, 32'd0);
    if (dev != 7'h04) check("R3 no enable for foreign write", {31'd0, oa}, 32'd0);
  endtask

  task automatic do_read(input logic [6:0] dev, input int a);
    logic [7:0] rb; logic oa, od;
    xfer({dev, 1'b1, 8'(a), 8'h5A}, 24, rb, oa, od);
    if (dev == 7'h04) begin
      check(is_rsv(a) ? "R7 reserved read zero" : "R5 read data", {24'd0, rb}, {24'd0, exp_read(a)});
      check("R5 enable across data byte", {31'd0, od}, 32'd1);
    end else begin
      check("R3 foreign read keeps sdo_en low", {31'd0, oa}, 32'd0);
    end
    check("R6 sdo_en low after read frame", {31'd0, sdo_en}, 32'd0);
    check_cfg("R9 read leaves registers");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    void'($urandom(32'd1974));
    repeat (5) @(negedge clk);
    check_cfg("R1 reset config zero");
    check("R1 reset sdo_en low", {31'd0, sdo_en}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // directed: plain write and readback at both ends of the map
    do_write(7'h04, 0, 8'hA5, 24);  check_cfg("R2 write reg0");
    do_write(7'h04, 16, 8'h3C, 24); check_cfg("R2 write reg16");
    do_read(7'h04, 0);
    do_read(7'h04, 16);
    // lock bit
    do_write(7'h04, 1, 8'hFF, 24);  check_cfg("R8 lock bit not stored");
    lock_in = 1'b1; do_read(7'h04, 1);
    lock_in = 1'b0; do_read(7'h04, 1);
    // reserved
    do_write(7'h04, 5, 8'hFF, 24);  check_cfg("R7 reserved write ignored");
    do_write(7'h04, 13, 8'h81, 24); check_cfg("R7 reserved write ignored");
    do_write(7'h04, 200, 8'h77, 24); check_cfg("R7 absent index ignored");
    do_read(7'h04, 9);
    // foreign device and bad lengths
    do_write(7'h05, 2, 8'h11, 24);  check_cfg("R3 foreign write ignored");
    do_read(7'h02, 0);
    do_write(7'h04, 3, 8'h99, 23);  check_cfg("R4 short frame discarded");
    do_write(7'h04, 3, 8'h99, 25);  check_cfg("R4 long frame discarded");

    // random mix
    for (int n = 0; n < 40; n++) begin
      int op = int'($urandom_range(0, 4));
      int a  = int'($urandom_range(0, NREG - 1));
      logic [7:0] v = 8'($urandom);
      lock_in = 1'($urandom);
      case (op)
        0, 1: begin do_write(7'h04, a, v, 24); check_cfg("R2 random write"); end
        2:    do_read(7'h04, a);
        3:    begin do_write(7'($urandom_range(5, 127)), a, v, 24); check_cfg("R3 random foreign"); end
        default: begin
          do_write(7'h04, a, v, $urandom_range(0, 1) ? 20 : 26);
          check_cfg("R4 random bad length");
        end
      endcase
    end
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule